// File: doc/BRIEF.md
# Three-Voice Tone and Noise Mixer

This block produces three square-wave tone voices and one shared pseudo-random noise stream, then gates each voice through an active-low enable mask. Each voice has a 12-bit period: the low byte is the fine part and bits 11:8 are the coarse part. A larger period gives a lower pitch. The noise source has a 5-bit period. The result is three 1-bit channel signals that a later stage scales by amplitude.

All timing comes from a clock-enable input `tick_en`. A prescaler divides the accepted ticks by 16, so one full output step takes 16 ticks. The tone counters advance twice per step, on half-steps, and each tone flips once per period. A full tone cycle therefore lasts 16 × P ticks. This gives the pitch rule frequency = tick rate / 16 / P. The noise counter advances once per full step. Each time it expires, a 17-bit shift register moves by one place.

Top module: `tone_noise_mixer`

## Requirements
- R1: While reset is asserted, every tone level is 0 and the noise register holds 1, so its output bit is 1. A channel output during reset is therefore 0 unless its tone enable is off.
- R2: With tick_en held high from reset release and a fixed period P (1..4095), a tone level after k accepted ticks is floor(k / (8·P)) mod 2. Each level lasts 8·P ticks, the first half-cycle is low, and a full cycle lasts 16·P ticks.
- R3: A tone period of 0 behaves exactly as a period of 1.
- R4: The largest tone period, 4095, flips the tone for the first time after exactly 32760 accepted ticks.
- R5: A cycle with tick_en low advances no prescaler, counter, tone or noise state. All timing in R2, R6 and R7 counts accepted ticks only.
- R6: The noise register is 17 bits wide and resets to 1. It shifts right by one place after every 16·N accepted ticks, where N is the noise period and 0 counts as 1. The new bit 16 is the XOR of old bits 0 and 3, and the noise output is bit 0.
- R7: mix_ctrl is active low. Bit i (i = 0, 1, 2 for channels A, B, C) disables that channel's tone, and bit i+3 disables its noise. A channel's output is (tone OR bit i) AND (noise OR bit i+3).
- R8: A channel whose tone-disable and noise-disable bits are both 1 outputs a constant 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Clock enable; each high cycle is one accepted tick |
| period_a | input | 12 | Tone period for channel A (bits 11:8 coarse, 7:0 fine) |
| period_b | input | 12 | Tone period for channel B |
| period_c | input | 12 | Tone period for channel C |
| noise_period | input | 5 | Noise period in full prescaler steps |
| mix_ctrl | input | 6 | Active-low enables: bits 2:0 tone A..C, bits 5:3 noise A..C |
| chan_a | output | 1 | Gated output of channel A |
| chan_b | output | 1 | Gated output of channel B |
| chan_c | output | 1 | Gated output of channel C |

## Verification
Several rules are checked on every cycle. A cycle without a tick produces no strobe. A tone flips only on a half-step strobe, and the noise register shifts only on a full-step strobe; between those events the tone levels and the register hold steady. The noise register never becomes zero. The gating rules hold at the outputs: a channel with both sources off reads 1, and a channel with only its tone enabled follows that tone. The exact periods cannot be seen from one cycle. These are the 8·P half-cycles, period 0 acting as 1, the 32760-tick first flip at period 4095, the noise shift sequence and the sweep over all 64 mask values. The bench shows them by comparing every output on every cycle against an arithmetic model driven by the count of accepted ticks, including under an irregular tick pattern.

// File: rtl/tnm_pkg.sv
package tnm_pkg;

  localparam int LFSR_W   = 17;
  localparam int LFSR_TAP = 3;
  localparam int NCH      = 3;

  // A zero period is treated as one
  function automatic logic [15:0] eff_period(input logic [15:0] p);
    return (p == 16'd0) ? 16'd1 : p;
  endfunction

  // One shift of the noise register: feedback into the top bit
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[0] ^ s[LFSR_TAP], s[LFSR_W-1:1]};
  endfunction

  // Active-low gating of one channel
  function automatic logic mix_bit(input logic tone, input logic noise,
                                   input logic tone_off, input logic noise_off);
    return (tone | tone_off) & (noise | noise_off);
  endfunction

endpackage

// File: rtl/tnm_prescaler.sv
module tnm_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic half_stb,
  output logic full_stb
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(DIV / 2 - 1);

  logic [CW-1:0] cnt;

  assign full_stb = tick_en && (cnt == LAST);
  assign half_stb = tick_en && ((cnt == LAST) || (cnt == MID));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick_en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/tnm_period_counter.sv
module tnm_period_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] period,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;
  logic         hit;

  assign lim    = W'(tnm_pkg::eff_period(16'(period)));
  assign hit    = (cnt >= lim - W'(1));
  assign expire = step && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= hit ? '0 : cnt + W'(1);
    end
  end
endmodule

// File: rtl/tnm_noise_gen.sv
module tnm_noise_gen #(
  parameter int PW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  input  logic [PW-1:0]              period,
  output logic                       shift,
  output logic [tnm_pkg::LFSR_W-1:0] state,
  output logic                       noise_bit
);
  tnm_period_counter #(.W(PW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .period (period),
    .expire (shift)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= tnm_pkg::LFSR_W'(1);
    end else if (shift) begin
      state <= tnm_pkg::lfsr_step(state);
    end
  end

  assign noise_bit = state[0];
endmodule

// File: rtl/tone_noise_mixer.sv
module tone_noise_mixer #(
  parameter int TONE_W   = 12,
  parameter int NOISE_W  = 5,
  parameter int PRESCALE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic [TONE_W-1:0]  period_a,
  input  logic [TONE_W-1:0]  period_b,
  input  logic [TONE_W-1:0]  period_c,
  input  logic [NOISE_W-1:0] noise_period,
  input  logic [5:0]         mix_ctrl,
  output logic               chan_a,
  output logic               chan_b,
  output logic               chan_c
);
  import tnm_pkg::*;

  // Named internal events, observed by the bound checker
  logic                  half_stb;
  logic                  full_stb;
  logic [NCH-1:0]        tone_flip;
  logic [NCH-1:0]        tone_q;
  logic                  noise_shift;
  logic [LFSR_W-1:0]     lfsr_state;
  logic                  noise_bit;
  logic [NCH-1:0]        chan_vec;
  logic [TONE_W-1:0]     period_vec [NCH];

  assign period_vec[0] = period_a;
  assign period_vec[1] = period_b;
  assign period_vec[2] = period_c;

  tnm_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .half_stb (half_stb),
    .full_stb (full_stb)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_voice
    tnm_period_counter #(.W(TONE_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (half_stb),
      .period (period_vec[i]),
      .expire (tone_flip[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tone_q[i] <= 1'b0;
      end else if (tone_flip[i]) begin
        tone_q[i] <= ~tone_q[i];
      end
    end

    assign chan_vec[i] = mix_bit(tone_q[i], noise_bit, mix_ctrl[i], mix_ctrl[i+NCH]);
  end

  tnm_noise_gen #(.PW(NOISE_W)) u_noise (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (full_stb),
    .period    (noise_period),
    .shift     (noise_shift),
    .state     (lfsr_state),
    .noise_bit (noise_bit)
  );

  assign chan_a = chan_vec[0];
  assign chan_b = chan_vec[1];
  assign chan_c = chan_vec[2];
endmodule

// File: rtl/tnm_checker.sv
module tnm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        half_stb,
  input logic        full_stb,
  input logic [2:0]  tone_flip,
  input logic [2:0]  tone_q,
  input logic        noise_shift,
  input logic [16:0] lfsr_state,
  input logic [5:0]  mix_ctrl,
  input logic [2:0]  chan_vec
);
  AST_NO_TICK_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |-> (!half_stb && !full_stb)); // R5

  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    full_stb |-> half_stb); // R2

  AST_SHIFT_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    noise_shift |-> full_stb); // R6

  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !noise_shift |=> $stable(lfsr_state)); // R6

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != 17'd0); // R6

  for (genvar i = 0; i < 3; i++) begin : g_ch
    AST_FLIP_ON_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      tone_flip[i] |-> half_stb); // R2

    AST_TONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_flip[i] |=> $stable(tone_q[i])); // R5

    AST_BOTH_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mix_ctrl[i] && mix_ctrl[i+3]) |-> chan_vec[i]); // R8

    AST_TONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!mix_ctrl[i] && mix_ctrl[i+3]) |-> (chan_vec[i] == tone_q[i])); // R7
  end
endmodule

bind tone_noise_mixer tnm_checker u_tnm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .half_stb    (half_stb),
  .full_stb    (full_stb),
  .tone_flip   (tone_flip),
  .tone_q      (tone_q),
  .noise_shift (noise_shift),
  .lfsr_state  (lfsr_state),
  .mix_ctrl    (mix_ctrl),
  .chan_vec    (chan_vec)
);

// File: tb/tone_noise_mixer_bench.sv
module tone_noise_mixer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [11:0] period_a = '0, period_b = '0, period_c = '0;
  logic [4:0]  noise_period = '0;
  logic [5:0]  mix_ctrl = '0;
  logic        chan_a, chan_b, chan_c;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  tone_noise_mixer u_tone_noise_mixer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .period_a(period_a), .period_b(period_b), .period_c(period_c),
    .noise_period(noise_period), .mix_ctrl(mix_ctrl),
    .chan_a(chan_a), .chan_b(chan_b), .chan_c(chan_c)
  );

  function automatic int eff(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  // Noise value after a given number of shifts: new top bit = b0 ^ b3
  function automatic logic noise_after(input int shifts);
    logic [16:0] s = 17'd1;
    for (int j = 0; j < shifts; j++) s = {s[0] ^ s[3], s[16:1]};
    return s[0];
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: chan={c,b,a}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset(input int pa, input int pb, input int pc, input int pn,
                          input logic [5:0] m);
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0;
    period_a = 12'(pa); period_b = 12'(pb); period_c = 12'(pc);
    noise_period = 5'(pn); mix_ctrl = m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // mode 0: tick every cycle; mode 1: irregular ticks with an idle stretch
  task automatic run_cfg(input string req, input int pa, input int pb, input int pc,
                         input int pn, input logic [5:0] m, input int ncyc,
                         input int mode);
    int ticks = 0;
    int shifts = 0;
    logic nb = 1'b1;
    int p [3];
    logic [2:0] exp;
    p[0] = eff(pa); p[1] = eff(pb); p[2] = eff(pc);
    do_reset(pa, pb, pc, pn, m);
    for (int i = 0; i < ncyc; i++) begin
      logic t;
      t = (mode == 0) ? 1'b1 :
          (((i % 5) != 2) && ((i % 7) != 0) && !(i >= 100 && i < 160));
      tick_en = t;
      if (t) ticks++;
      @(negedge clk);
      if (ticks / (16 * eff(pn)) != shifts) begin
        shifts = ticks / (16 * eff(pn));
        nb = noise_after(shifts);
      end
      for (int c = 0; c < 3; c++) begin
        logic tn;
        tn = 1'((ticks / (8 * p[c])) % 2);
        exp[c] = (tn | m[c]) & (nb | m[c+3]);
      end
      check(req, {chan_c, chan_b, chan_a}, exp);
    end
    tick_en = 1'b0;
  endtask

  initial begin
    // R1: reset state, all enabled -> 0; tones disabled -> noise bit 1
    rst_n = 1'b0;
    mix_ctrl = 6'b000000;
    repeat (3) @(negedge clk);
    check("R1", {chan_c, chan_b, chan_a}, 3'b000);
    mix_ctrl = 6'b000111;
    @(negedge clk);
    check("R1", {chan_c, chan_b, chan_a}, 3'b111);

    // R2: tone only, several periods
    run_cfg("R2", 5, 1, 2, 3, 6'b111000, 400, 0);
    run_cfg("R2", 7, 11, 4, 1, 6'b111000, 600, 0);
    // R3: zero period equals one
    run_cfg("R3", 0, 3, 0, 0, 6'b111000, 300, 0);
    // R4: maximum period, first flip at 32760 ticks
    run_cfg("R4", 4095, 1, 0, 2, 6'b111000, 32800, 0);
    // R5: irregular tick enable
    run_cfg("R5", 2, 3, 4, 2, 6'b000000, 600, 1);
    run_cfg("R5", 1, 5, 0, 0, 6'b000111, 700, 1);
    // R6: noise only, several noise periods
    run_cfg("R6", 1, 1, 1, 0, 6'b000111, 800, 0);
    run_cfg("R6", 1, 1, 1, 2, 6'b000111, 800, 0);
    run_cfg("R6", 1, 1, 1, 31, 6'b000111, 3000, 0);
    // R7: full sweep of the mask
    for (int mv = 0; mv < 64; mv++)
      run_cfg("R7", 1, 2, 3, 1, 6'(mv), 150, 0);
    // R8: both sources off on every channel
    run_cfg("R8", 3, 4, 5, 1, 6'b111111, 200, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule